// File: doc/BRIEF.md
# Bar Graph Raster Generator

This block generates a complete 640x480, 60 Hz analog-monitor raster and paints a bar graph into it. Its only timing input is a 100 MHz system clock. A divide-by-four counter produces a one-cycle pixel enable, and every register in the block advances only on that enable. Column and line counters sweep the full 800 x 525 position space. From those counters the block derives the active-low line and frame sync pulses and the colour of each pixel.

The bar graph is made of columns one pixel wide. Each visible column takes its height from a computed table that is addressed by the 10-bit column count. The bar rises in red from just above a baseline row. The baseline is painted green across the whole visible width. Everything else is black, including all blanking intervals. The colour output and both sync outputs are registered, so the sync timing and the pixel stream share the same single-enable delay.

Top module: `vga_bar_top`

## Requirements
- R1: A pixel enable fires once every CLK_DIV (default 4) clock cycles. The rgb, hsync_n and vsync_n outputs change only on clock edges where the enable is high. After the n-th enable (counted from 0 since reset), the outputs show the raster position n.
- R2: A line has 800 positions: 640 visible, then a 16-position front porch, a 96-position sync interval and a 48-position back porch. The column count wraps from 799 to 0, and the line count advances by one on that wrap.
- R3: hsync_n is low exactly for columns 656 to 751 and high for all other columns.
- R4: A frame has 525 lines, of which 480 are visible (then a 10-line front porch, a 2-line sync and a 33-line back porch). The line count wraps from 524 to 0.
- R5: vsync_n is low exactly on lines 490 and 491 and high on all other lines.
- R6: Every visible pixel on baseline row 239 is green, 12'h0F0 (bits 11:8 red, 7:4 green, 3:0 blue).
- R7: A visible pixel at row y above the baseline is red, 12'hF00, when y >= 239 - H, where H is the column's effective bar height.
- R8: The bar height of column x is (37 * x) mod 256, an 8-bit value taken from the 10-bit column count.
- R9: Every other pixel is black, 12'h000. This includes every pixel in the horizontal or vertical blanking.
- R10: While rst is high at a clock edge, both counters and the divider are cleared, rgb becomes 12'h000, and hsync_n and vsync_n become high. The first enable comes CLK_DIV cycles after reset is released.
- R11: A bar height greater than the baseline row is clamped to it, so such a column is red from row 0 down to the row just above the baseline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 100 MHz nominal |
| rst | input | 1 | Synchronous reset, active high |
| hsync_n | output | 1 | Line sync, active low, registered |
| vsync_n | output | 1 | Frame sync, active low, registered |
| rgb | output | 12 | Pixel colour, 4 bits each for red, green and blue, registered |

## Verification
On every cycle the assertions check several properties. They check the spacing of the pixel enable and that outputs hold between enables. They check the column and line wrap points and the line advance. They check that each sync output equals its window as decoded from the counters one enable earlier, and that blanking and baseline pixels take the right colours. They also check the reset values. They cannot show that the bar shape matches the height formula, that saturation clamps correctly, or that whole frames repeat after a wrap. Those come only from the bench's scenarios, which compare every output against a model of position n after the n-th enable. The bench runs over more than a full frame with reduced timing parameters and again after a reset in mid-frame.

// File: rtl/vga_bar_pkg.sv
package vga_bar_pkg;

    localparam int CNT_W       = 10;
    localparam int HEIGHT_W    = 8;
    localparam int HEIGHT_STEP = 37;

    typedef logic [CNT_W-1:0]    coord_t;
    typedef logic [HEIGHT_W-1:0] height_t;

    typedef struct packed {
        coord_t col;
        coord_t row;
    } raster_pos_t;

    typedef struct packed {
        logic [3:0] r;
        logic [3:0] g;
        logic [3:0] b;
    } rgb12_t;

    typedef enum logic [1:0] {
        PIX_DARK,
        PIX_BAR,
        PIX_AXIS
    } pix_kind_e;

    localparam rgb12_t COLOR_BLACK = '{r: 4'h0, g: 4'h0, b: 4'h0};
    localparam rgb12_t COLOR_RED   = '{r: 4'hF, g: 4'h0, b: 4'h0};
    localparam rgb12_t COLOR_GREEN = '{r: 4'h0, g: 4'hF, b: 4'h0};

    // Height table computed from the column address instead of stored.
    function automatic height_t column_height(coord_t col);
        return HEIGHT_W'(col * coord_t'(HEIGHT_STEP));
    endfunction

    function automatic rgb12_t kind_color(pix_kind_e kind);
        rgb12_t c;
        case (kind)
            PIX_BAR:  c = COLOR_RED;
            PIX_AXIS: c = COLOR_GREEN;
            default:  c = COLOR_BLACK;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pixel_tick_gen.sv
module pixel_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/raster_counter.sv
module raster_counter
    import vga_bar_pkg::*;
#(
    parameter int H_TOTAL = 800,
    parameter int V_TOTAL = 525
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    output raster_pos_t pos,
    output logic        line_end
);
    localparam coord_t H_LAST = coord_t'(H_TOTAL - 1);
    localparam coord_t V_LAST = coord_t'(V_TOTAL - 1);

    assign line_end = (pos.col == H_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (tick) begin
            if (line_end) begin
                pos.col <= '0;
                pos.row <= (pos.row == V_LAST) ? '0 : pos.row + 1'b1;
            end else begin
                pos.col <= pos.col + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bar_table.sv
module bar_table
    import vga_bar_pkg::*;
(
    input  coord_t  col,
    output height_t height
);
    assign height = column_height(col);
endmodule

// File: rtl/bar_pixel_unit.sv
module bar_pixel_unit
    import vga_bar_pkg::*;
#(
    parameter int H_VIS    = 640,
    parameter int H_FP     = 16,
    parameter int H_SYNC   = 96,
    parameter int V_VIS    = 480,
    parameter int V_FP     = 10,
    parameter int V_SYNC   = 2,
    parameter int BASE_ROW = 239
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  raster_pos_t pos,
    input  height_t     height,
    output rgb12_t      rgb_q,
    output logic        hsync_n,
    output logic        vsync_n
);
    localparam coord_t H_VIS_C   = coord_t'(H_VIS);
    localparam coord_t V_VIS_C   = coord_t'(V_VIS);
    localparam coord_t HS_START  = coord_t'(H_VIS + H_FP);
    localparam coord_t HS_END    = coord_t'(H_VIS + H_FP + H_SYNC);
    localparam coord_t VS_START  = coord_t'(V_VIS + V_FP);
    localparam coord_t VS_END    = coord_t'(V_VIS + V_FP + V_SYNC);
    localparam coord_t BASE_C    = coord_t'(BASE_ROW);

    logic      visible, in_hs, in_vs, is_bar;
    coord_t    h_ext, h_eff, bar_top;
    pix_kind_e kind;

    always_comb begin
        visible = (pos.col < H_VIS_C) && (pos.row < V_VIS_C);
        in_hs   = (pos.col >= HS_START) && (pos.col < HS_END);
        in_vs   = (pos.row >= VS_START) && (pos.row < VS_END);
        h_ext   = coord_t'(height);
        h_eff   = (h_ext > BASE_C) ? BASE_C : h_ext;
        bar_top = BASE_C - h_eff;
        is_bar  = (pos.row < BASE_C) && (pos.row >= bar_top);
        if (!visible)              kind = PIX_DARK;
        else if (pos.row == BASE_C) kind = PIX_AXIS;
        else if (is_bar)            kind = PIX_BAR;
        else                        kind = PIX_DARK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rgb_q   <= COLOR_BLACK;
            hsync_n <= 1'b1;
            vsync_n <= 1'b1;
        end else if (tick) begin
            rgb_q   <= kind_color(kind);
            hsync_n <= !in_hs;
            vsync_n <= !in_vs;
        end
    end
endmodule

// File: rtl/vga_bar_top.sv
module vga_bar_top
    import vga_bar_pkg::*;
#(
    parameter int CLK_DIV  = 4,
    parameter int H_VIS    = 640,
    parameter int H_FP     = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BP     = 48,
    parameter int V_VIS    = 480,
    parameter int V_FP     = 10,
    parameter int V_SYNC   = 2,
    parameter int V_BP     = 33,
    parameter int BASE_ROW = 239
) (
    input  logic        clk,
    input  logic        rst,
    output logic        hsync_n,
    output logic        vsync_n,
    output logic [11:0] rgb
);
    localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;

    logic        tick;
    logic        line_end;
    raster_pos_t pos;
    height_t     col_height;
    rgb12_t      rgb_q;

    pixel_tick_gen #(.DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    raster_counter #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .pos      (pos),
        .line_end (line_end)
    );

    bar_table u_table (
        .col    (pos.col),
        .height (col_height)
    );

    bar_pixel_unit #(
        .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC),
        .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC),
        .BASE_ROW(BASE_ROW)
    ) u_pix (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .pos     (pos),
        .height  (col_height),
        .rgb_q   (rgb_q),
        .hsync_n (hsync_n),
        .vsync_n (vsync_n)
    );

    assign rgb = rgb_q;
endmodule

// File: rtl/vga_bar_checker.sv
module vga_bar_checker
    import vga_bar_pkg::*;
#(
    parameter int CLK_DIV  = 4,
    parameter int H_VIS    = 640,
    parameter int H_FP     = 16,
    parameter int H_SYNC   = 96,
    parameter int H_TOTAL  = 800,
    parameter int V_VIS    = 480,
    parameter int V_FP     = 10,
    parameter int V_SYNC   = 2,
    parameter int V_TOTAL  = 525,
    parameter int BASE_ROW = 239
) (
    input logic        clk,
    input logic        rst,
    input logic        tick,
    input coord_t      col,
    input coord_t      row,
    input logic        line_end,
    input logic        hsync_n,
    input logic        vsync_n,
    input logic [11:0] rgb
);
    localparam coord_t H_LAST   = coord_t'(H_TOTAL - 1);
    localparam coord_t V_LAST   = coord_t'(V_TOTAL - 1);
    localparam coord_t H_VIS_C  = coord_t'(H_VIS);
    localparam coord_t V_VIS_C  = coord_t'(V_VIS);
    localparam coord_t HS_START = coord_t'(H_VIS + H_FP);
    localparam coord_t HS_END   = coord_t'(H_VIS + H_FP + H_SYNC);
    localparam coord_t VS_START = coord_t'(V_VIS + V_FP);
    localparam coord_t VS_END   = coord_t'(V_VIS + V_FP + V_SYNC);
    localparam coord_t BASE_C   = coord_t'(BASE_ROW);

    int gap;
    always_ff @(posedge clk) begin
        if (rst || tick) gap <= 0;
        else             gap <= gap + 1;
    end

    a_r1_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        tick |-> (gap == CLK_DIV - 1));

    a_r1_hold_between: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(rgb) && $stable(hsync_n) && $stable(vsync_n)));

    a_r2_col_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && col == H_LAST) |=> (col == '0));

    a_r2_row_step: assert property (@(posedge clk) disable iff (rst)
        (tick && line_end && row != V_LAST) |=> (row == $past(row) + 1'b1));

    a_r4_row_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && line_end && row == V_LAST) |=> (row == '0));

    a_r3_hsync_window: assert property (@(posedge clk) disable iff (rst)
        tick |=> (hsync_n == !($past(col) >= HS_START && $past(col) < HS_END)));

    a_r5_vsync_window: assert property (@(posedge clk) disable iff (rst)
        tick |=> (vsync_n == !($past(row) >= VS_START && $past(row) < VS_END)));

    a_r9_blank_black: assert property (@(posedge clk) disable iff (rst)
        (tick && !(col < H_VIS_C && row < V_VIS_C)) |=> (rgb == 12'h000));

    a_r6_axis_green: assert property (@(posedge clk) disable iff (rst)
        (tick && col < H_VIS_C && row == BASE_C) |=> (rgb == 12'h0F0));

    a_r10_reset_state: assert property (@(posedge clk)
        rst |=> (rgb == 12'h000 && hsync_n && vsync_n && col == '0 && row == '0));
endmodule

bind vga_bar_top vga_bar_checker #(
    .CLK_DIV(CLK_DIV), .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC),
    .H_TOTAL(H_TOTAL), .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC),
    .V_TOTAL(V_TOTAL), .BASE_ROW(BASE_ROW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .col      (pos.col),
    .row      (pos.row),
    .line_end (line_end),
    .hsync_n  (hsync_n),
    .vsync_n  (vsync_n),
    .rgb      (rgb)
);

// File: tb/vga_bar_top_tb.sv
module vga_bar_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV   = 4;
    localparam int HV = 64, HF = 4, HS = 8, HB = 4;
    localparam int VV = 48, VF = 2, VS = 2, VB = 3;
    localparam int BASE = 23;
    localparam int HT = HV + HF + HS + HB;
    localparam int VT = VV + VF + VS + VB;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hsync_n, vsync_n;
    logic [11:0] rgb;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [11:0] prev_rgb;
    logic        prev_hs, prev_vs;

    always #(CLK_PERIOD/2) clk = ~clk;

    vga_bar_top #(
        .CLK_DIV(DIV), .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
        .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB), .BASE_ROW(BASE)
    ) u_dut (
        .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n), .rgb(rgb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected pixel for raster position index n (R6 R7 R8 R9 R11).
    task automatic model(input int n, output int exp_rgb, output int exp_hs,
                         output int exp_vs, output string req);
        int col = n % HT;
        int row = (n / HT) % VT;
        int h   = (37 * col) % 256;
        int eff = (h > BASE) ? BASE : h;
        exp_hs = (col >= HV + HF && col < HV + HF + HS) ? 0 : 1;
        exp_vs = (row >= VV + VF && row < VV + VF + VS) ? 0 : 1;
        if (col < HV && row < VV) begin
            if (row == BASE) begin
                exp_rgb = 12'h0F0; req = "R6";
            end else if (row < BASE && row >= BASE - eff) begin
                exp_rgb = 12'hF00; req = (h > BASE) ? "R11 R7 R8" : "R7 R8";
            end else begin
                exp_rgb = 12'h000; req = "R9 R8";
            end
        end else begin
            exp_rgb = 12'h000; req = "R9";
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk(rgb == 12'h000, "R10 rgb", rgb, 0);
        chk(hsync_n == 1'b1, "R10 hsync_n", hsync_n, 1);
        chk(vsync_n == 1'b1, "R10 vsync_n", vsync_n, 1);
        prev_rgb = rgb; prev_hs = hsync_n; prev_vs = vsync_n;
    endtask

    // Steps n_ticks enables from a freshly released reset (R1 R2 R4).
    task automatic t_scan(input int n_ticks);
        for (int n = 0; n < n_ticks; n++) begin
            for (int c = 1; c <= DIV; c++) begin
                @(posedge clk);
                @(negedge clk);
                if (c < DIV) begin
                    chk(rgb == prev_rgb && hsync_n == prev_hs && vsync_n == prev_vs,
                        "R1 hold", {rgb, hsync_n, vsync_n}, {prev_rgb, prev_hs, prev_vs});
                end else begin
                    int er, eh, ev;
                    string rq;
                    model(n, er, eh, ev, rq);
                    chk(rgb == 12'(er), rq, rgb, er);
                    chk(hsync_n == 1'(eh), "R3 R2 R1 hsync", hsync_n, eh);
                    chk(vsync_n == 1'(ev), "R5 R4 vsync", vsync_n, ev);
                end
                prev_rgb = rgb; prev_hs = hsync_n; prev_vs = vsync_n;
            end
        end
    endtask

    // Reset during a frame, in the red bar area (R10).
    task automatic t_mid_reset();
        rst = 1'b1;
        @(posedge clk);
        t_reset_state();
        @(posedge clk);
        @(negedge clk);
        chk(rgb == 12'h000 && hsync_n && vsync_n, "R10 held", {rgb, hsync_n, vsync_n}, 12'h000 << 2 | 3);
        rst = 1'b0;
        prev_rgb = rgb; prev_hs = hsync_n; prev_vs = vsync_n;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset_state();
        rst = 1'b0;
        t_scan(HT * VT + 2 * HT);
        t_scan(0);
        // Run into the bar area then reset mid-frame.
        repeat (DIV * (HT * 5 + 7)) @(posedge clk);
        @(negedge clk);
        t_mid_reset();
        t_scan(3 * HT);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule